// File: doc/BRIEF.md
# Synchronous Host Bus to Wishbone Bridge

This block sits inside an FPGA and lets a processor reach an internal Wishbone bus over the processor's synchronous external memory interface. The external bus is 16 bits wide and carries both address and data on the same lines. The processor supplies the bus clock, which runs at 50 MHz (20 ns period), and the whole bridge runs in that clock domain. An access starts with an address phase: chip-select and address-valid are both low, and the write-enable level on that edge sets the direction. Data beats then follow on the same lines.

A build-time switch selects one of two modes. The default mode is conservative and allows one word per access. The burst mode moves a fixed 16 beats per access, one word per bus clock. Reads have a fixed latency of six bus clocks to the first word. In burst mode the bridge keeps prefetching over Wishbone, so each later word is ready one clock after the one before it. That makes a 32-byte read take 6 + 15 clocks.

Writes are posted through the same small buffer. Their pace depends only on the host, not on the read latency. Raising chip-select ends any access early.

Top module: `hbw_bridge`

## Requirements
- R1: While reset is active, `wb_cyc_o`, `wb_stb_o` and `hb_ad_oe` are low and `hb_ad_out` is zero.
- R2: When the bridge is idle, the value on `hb_ad_in` is latched as a word address on the clock edge where `hb_cs_n` and `hb_adv_n` are both low. A low `hb_we_n` on that edge marks a write and a high one marks a read. The first Wishbone cycle of the access carries this address in the clock cycle that follows.
- R3: For a read, the word that Wishbone returns for the latched address is on `hb_ad_out` after the 5th rising edge that follows the address edge. The host therefore samples it on the 6th edge (RD_LAT = 6, 120 ns at 50 MHz).
- R4: With BURST_EN = 1, a read delivers 16 words from consecutive incrementing word addresses. Word k is sampled by the host on edge 6 + k after the address edge, for k = 0..15, with no wait cycles, so the last word arrives on edge 21.
- R5: With BURST_EN = 0, an access makes exactly one Wishbone transfer. `hb_ad_out` keeps the word until the next read, and any write beat after the first is ignored.
- R6: A write beat is captured on every edge where `hb_cs_n` and `hb_we_n` are low and `hb_adv_n` is high. Beats go to Wishbone in order at consecutive addresses starting from the latched one. The first Wishbone write is presented in the clock after its capture, whatever RD_LAT is.
- R7: `hb_ad_oe` is high only while `hb_cs_n` and `hb_oe_n` are both low during a read access, and it is low at all other times.
- R8: Raising `hb_cs_n` during a read ends the access. `wb_cyc_o` is low in the clock after that edge, prefetched words are discarded, and the next access returns its own data.
- R9: `wb_stb_o` is never high without `wb_cyc_o`. While chip-select stays low, a strobe without acknowledge is held with a stable address into the next clock.
- R10: With BURST_EN = 1, write beats beyond the 16th in one access are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock driven by the host |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_cs_n | input | 1 | Chip-select, active low |
| hb_adv_n | input | 1 | Address-valid strobe, active low |
| hb_oe_n | input | 1 | Output enable from the host, active low |
| hb_we_n | input | 1 | Write enable from the host, active low |
| hb_ad_in | input | BUS_W | Multiplexed address/data from the pad |
| hb_ad_out | output | BUS_W | Read data to the pad |
| hb_ad_oe | output | 1 | Pad drive enable; high drives `hb_ad_out` onto the shared lines |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | BUS_W | Wishbone word address |
| wb_dat_o | output | BUS_W | Wishbone write data |
| wb_dat_i | input | BUS_W | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
The bound checker watches several rules on every clock:
- the Wishbone strobe never appears without a cycle, and it holds until acknowledged;
- the pad is driven only under chip-select and output-enable;
- the buffer never overruns, and it is never popped empty at the fixed read deadline;
- the cycle drops right after chip-select ends a read;
- the address is latched in the clock after the address phase.

Only the bench's directed scenarios can show the exact edge counts of 6 and 6+15 and the word order in a burst. They also show that later write beats are discarded in each build, that writes land in the clock after capture, and that data fetched before an abort does not leak into the next read.

// File: rtl/hbw_pkg.sv
// Shared types for the host bus to Wishbone bridge.
package hbw_pkg;

    // Access sequencer states
    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_READ  = 2'd1,
        HB_WRITE = 2'd2,
        HB_HOLD  = 2'd3
    } hb_state_e;

endpackage

// File: rtl/hbw_fifo.sv
// Small word buffer shared by read prefetch and write posting.
// Assumes: the producer respects full unless it pops in the same cycle;
// flush wins over push and pop in the same cycle.
module hbw_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [LVL_W-1:0] level_q;
    logic             do_push;
    logic             do_pop;

    assign empty   = (level_q == '0);
    assign full    = (level_q == LVL_FULL);
    assign level   = level_q;
    assign head    = slot_q[rd_ptr_q];
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    // Storage write: data slots need no reset
    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            slot_q[wr_ptr_q] <= din;
        end
    end

    // Pointer and fill tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_pop) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

endmodule

// File: rtl/hbw_seq.sv
// Host-side access sequencer: latches the direction on the address
// edge, counts the fixed read latency, times the read pops and write
// captures, and counts beats up to the build's limit.
// Assumes: the host holds chip-select low for the whole access and raises
// it to end one; a new address is accepted only once the buffer is empty.
module hbw_seq
    import hbw_pkg::*;
#(
    parameter int BURST_LEN = 16,
    parameter bit BURST_EN  = 1'b0,
    parameter int RD_LAT    = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      adv_n,
    input  logic      we_n,
    input  logic      buf_empty,
    output hb_state_e state,
    output logic      start,
    output logic      wr_mode,
    output logic      rd_pop,
    output logic      wr_cap,
    output logic      rd_abort
);

    localparam int BEATS = BURST_EN ? BURST_LEN : 1;
    localparam int CNT_W = $clog2(BURST_LEN + 1);
    localparam int LAT_W = $clog2(RD_LAT + 1);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);
    localparam logic [LAT_W-1:0] POP_AT    = LAT_W'(RD_LAT - 1);

    hb_state_e        state_q;
    logic [CNT_W-1:0] beat_q;
    logic [LAT_W-1:0] lat_q;
    logic             wr_mode_q;

    assign state    = state_q;
    assign wr_mode  = wr_mode_q;
    assign start    = (state_q == HB_IDLE) && !cs_n && !adv_n && buf_empty;
    assign rd_pop   = (state_q == HB_READ) && !cs_n && (lat_q >= POP_AT);
    assign wr_cap   = (state_q == HB_WRITE) && !cs_n && !we_n && adv_n;
    assign rd_abort = (state_q == HB_READ) && cs_n;

    // Access state, latency and beat counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= HB_IDLE;
            beat_q    <= '0;
            lat_q     <= '0;
            wr_mode_q <= 1'b0;
        end else begin
            case (state_q)
                HB_IDLE: begin
                    if (start) begin
                        state_q   <= we_n ? HB_READ : HB_WRITE;
                        wr_mode_q <= !we_n;
                        beat_q    <= '0;
                        lat_q     <= LAT_W'(1);
                    end
                end
                HB_READ: begin
                    if (cs_n) begin
                        state_q <= HB_IDLE;
                    end else begin
                        if (lat_q < POP_AT) begin
                            lat_q <= lat_q + 1'b1;
                        end
                        if (rd_pop) begin
                            if (beat_q == LAST_BEAT) begin
                                state_q <= HB_HOLD;
                            end else begin
                                beat_q <= beat_q + 1'b1;
                            end
                        end
                    end
                end
                HB_WRITE: begin
                    if (cs_n) begin
                        state_q <= HB_IDLE;
                    end else if (wr_cap) begin
                        if (beat_q == LAST_BEAT) begin
                            state_q <= HB_HOLD;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (cs_n) begin
                        state_q <= HB_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/hbw_wb_master.sv
// Wishbone master side: issues read prefetches while the buffer has room,
// drains posted writes, and steps the word address on every acknowledge.
// Assumes: a classic Wishbone slave with one transfer outstanding; read
// acknowledges arrive fast enough that a word is buffered by each pop.
module hbw_wb_master #(
    parameter int BUS_W     = 16,
    parameter int BURST_LEN = 16,
    parameter bit BURST_EN  = 1'b0,
    parameter int DEPTH     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [BUS_W-1:0]           start_adr,
    input  logic                       rd_busy,
    input  logic                       wr_mode,
    input  logic [$clog2(DEPTH+1)-1:0] buf_level,
    input  logic                       buf_empty,
    input  logic [BUS_W-1:0]           buf_head,
    input  logic                       wb_ack_i,
    output logic                       wb_cyc_o,
    output logic                       wb_stb_o,
    output logic                       wb_we_o,
    output logic [BUS_W-1:0]           wb_adr_o,
    output logic [BUS_W-1:0]           wb_dat_o,
    output logic                       rd_fill,
    output logic                       wr_done
);

    localparam int BEATS = BURST_EN ? BURST_LEN : 1;
    localparam int CNT_W = $clog2(BURST_LEN + 1);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] BEATS_C = CNT_W'(BEATS);
    localparam logic [LVL_W-1:0] ROOM_C  = LVL_W'(DEPTH);

    logic [CNT_W-1:0] issued_q;
    logic [BUS_W-1:0] adr_q;
    logic             rd_req;
    logic             wr_req;

    assign rd_req   = rd_busy && (issued_q < BEATS_C) && (buf_level < ROOM_C);
    assign wr_req   = wr_mode && !buf_empty;
    assign wb_stb_o = rd_req || wr_req;
    assign wb_cyc_o = wb_stb_o;
    assign wb_we_o  = wr_req;
    assign wb_adr_o = adr_q;
    assign wb_dat_o = buf_head;
    assign rd_fill  = rd_req && wb_ack_i;
    assign wr_done  = wr_req && wb_ack_i;

    // Word address: load on the address phase, step per acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q <= '0;
        end else if (start) begin
            adr_q <= start_adr;
        end else if (wb_stb_o && wb_ack_i) begin
            adr_q <= adr_q + 1'b1;
        end
    end

    // Count read prefetches so a burst never fetches past its length
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            issued_q <= '0;
        end else if (rd_fill) begin
            issued_q <= issued_q + 1'b1;
        end
    end

endmodule

// File: rtl/hbw_bridge.sv
// Top of the host bus to Wishbone bridge. Wires the sequencer, the shared
// buffer and the Wishbone master, and registers read data for the pad.
// Assumes: everything runs on the host's bus clock; the pad is a tri-state
// buffer driven by hb_ad_out under hb_ad_oe.
module hbw_bridge
    import hbw_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter bit BURST_EN  = 1'b0,
    parameter int BURST_LEN = 16,
    parameter int RD_LAT    = 6,
    parameter int BUF_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb_cs_n,
    input  logic             hb_adv_n,
    input  logic             hb_oe_n,
    input  logic             hb_we_n,
    input  logic [BUS_W-1:0] hb_ad_in,
    output logic [BUS_W-1:0] hb_ad_out,
    output logic             hb_ad_oe,
    output logic             wb_cyc_o,
    output logic             wb_stb_o,
    output logic             wb_we_o,
    output logic [BUS_W-1:0] wb_adr_o,
    output logic [BUS_W-1:0] wb_dat_o,
    input  logic [BUS_W-1:0] wb_dat_i,
    input  logic             wb_ack_i
);

    localparam int LVL_W = $clog2(BUF_DEPTH + 1);

    hb_state_e        state;
    logic             start;
    logic             wr_mode;
    logic             rd_pop;
    logic             wr_cap;
    logic             rd_abort;
    logic             rd_busy;
    logic             rd_fill;
    logic             wr_done;
    logic             buf_push;
    logic             buf_pop;
    logic             buf_empty;
    logic             buf_full;
    logic [LVL_W-1:0] buf_level;
    logic [BUS_W-1:0] buf_din;
    logic [BUS_W-1:0] buf_head;
    logic [BUS_W-1:0] rd_word_q;

    assign rd_busy  = (state == HB_READ);
    assign buf_push = rd_fill || wr_cap;
    assign buf_din  = wr_cap ? hb_ad_in : wb_dat_i;
    assign buf_pop  = rd_pop || wr_done;

    hbw_seq #(
        .BURST_LEN (BURST_LEN),
        .BURST_EN  (BURST_EN),
        .RD_LAT    (RD_LAT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (hb_cs_n),
        .adv_n     (hb_adv_n),
        .we_n      (hb_we_n),
        .buf_empty (buf_empty),
        .state     (state),
        .start     (start),
        .wr_mode   (wr_mode),
        .rd_pop    (rd_pop),
        .wr_cap    (wr_cap),
        .rd_abort  (rd_abort)
    );

    hbw_fifo #(
        .W     (BUS_W),
        .DEPTH (BUF_DEPTH)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rd_abort),
        .push  (buf_push),
        .din   (buf_din),
        .pop   (buf_pop),
        .head  (buf_head),
        .empty (buf_empty),
        .full  (buf_full),
        .level (buf_level)
    );

    hbw_wb_master #(
        .BUS_W     (BUS_W),
        .BURST_LEN (BURST_LEN),
        .BURST_EN  (BURST_EN),
        .DEPTH     (BUF_DEPTH)
    ) u_wbm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_adr (hb_ad_in),
        .rd_busy   (rd_busy),
        .wr_mode   (wr_mode),
        .buf_level (buf_level),
        .buf_empty (buf_empty),
        .buf_head  (buf_head),
        .wb_ack_i  (wb_ack_i),
        .wb_cyc_o  (wb_cyc_o),
        .wb_stb_o  (wb_stb_o),
        .wb_we_o   (wb_we_o),
        .wb_adr_o  (wb_adr_o),
        .wb_dat_o  (wb_dat_o),
        .rd_fill   (rd_fill),
        .wr_done   (wr_done)
    );

    // Read data register: updated on the fixed-latency pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word_q <= '0;
        end else if (rd_pop) begin
            rd_word_q <= buf_head;
        end
    end

    assign hb_ad_out = rd_word_q;
    assign hb_ad_oe  = !hb_cs_n && !hb_oe_n && !wr_mode &&
                       ((state == HB_READ) || (state == HB_HOLD));

endmodule

// File: rtl/hbw_bridge_chk.sv
// Protocol checker for the bridge, attached to every instance by bind.
module hbw_bridge_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             oe_n,
    input logic [BUS_W-1:0] ad_in,
    input logic             ad_oe,
    input logic             wb_cyc,
    input logic             wb_stb,
    input logic             wb_ack,
    input logic [BUS_W-1:0] wb_adr,
    input logic             start,
    input logic             rd_busy,
    input logic             rd_pop,
    input logic             buf_empty,
    input logic             buf_full,
    input logic             buf_push,
    input logic             buf_pop
);

    // R9
    stb_in_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> wb_cyc);

    // R9
    stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && !wb_ack && !cs_n) |=> (wb_stb && $stable(wb_adr)));

    // R7
    pad_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!cs_n && !oe_n));

    // R8
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && cs_n) |=> !wb_cyc);

    // R3
    pop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |-> !buf_empty);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_push |-> (!buf_full || buf_pop));

    // R2
    addr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (wb_adr == $past(ad_in)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && wb_ack && !start) |=> (wb_adr == $past(wb_adr) + BUS_W'(1)));

endmodule

bind hbw_bridge hbw_bridge_chk #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (hb_cs_n),
    .oe_n      (hb_oe_n),
    .ad_in     (hb_ad_in),
    .ad_oe     (hb_ad_oe),
    .wb_cyc    (wb_cyc_o),
    .wb_stb    (wb_stb_o),
    .wb_ack    (wb_ack_i),
    .wb_adr    (wb_adr_o),
    .start     (start),
    .rd_busy   (rd_busy),
    .rd_pop    (rd_pop),
    .buf_empty (buf_empty),
    .buf_full  (buf_full),
    .buf_push  (buf_push),
    .buf_pop   (buf_pop)
);

// File: tb/hbw_bridge_bench.sv
// Directed bench: one host model drives a burst build and a single-access
// build side by side, each with its own zero-wait Wishbone memory.
module hbw_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [15:0] ad_in = '0;

    logic [15:0] ado_b, adr_b, dato_b, dati_b;
    logic        oe_b, cyc_b, stb_b, we_b, ack_b;
    logic [15:0] ado_s, adr_s, dato_s, dati_s;
    logic        oe_s, cyc_s, stb_s, we_s, ack_s;

    logic [15:0] mem_b [256];
    logic [15:0] mem_s [256];

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [15:0] pat(input int i);
        return {8'(i) ^ 8'hA5, 8'(i)};
    endfunction

    hbw_bridge #(.BURST_EN(1'b1)) u_hbw_bridge (
        .clk(clk), .rst_n(rst_n), .hb_cs_n(cs_n), .hb_adv_n(adv_n),
        .hb_oe_n(oe_n), .hb_we_n(we_n), .hb_ad_in(ad_in),
        .hb_ad_out(ado_b), .hb_ad_oe(oe_b), .wb_cyc_o(cyc_b),
        .wb_stb_o(stb_b), .wb_we_o(we_b), .wb_adr_o(adr_b),
        .wb_dat_o(dato_b), .wb_dat_i(dati_b), .wb_ack_i(ack_b)
    );

    hbw_bridge #(.BURST_EN(1'b0)) u_hbw_bridge_sgl (
        .clk(clk), .rst_n(rst_n), .hb_cs_n(cs_n), .hb_adv_n(adv_n),
        .hb_oe_n(oe_n), .hb_we_n(we_n), .hb_ad_in(ad_in),
        .hb_ad_out(ado_s), .hb_ad_oe(oe_s), .wb_cyc_o(cyc_s),
        .wb_stb_o(stb_s), .wb_we_o(we_s), .wb_adr_o(adr_s),
        .wb_dat_o(dato_s), .wb_dat_i(dati_s), .wb_ack_i(ack_s)
    );

    // Zero-wait memory models
    assign ack_b  = cyc_b && stb_b;
    assign dati_b = mem_b[adr_b[7:0]];
    assign ack_s  = cyc_s && stb_s;
    assign dati_s = mem_s[adr_s[7:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem_b[i] <= pat(i);
        end else if (cyc_b && stb_b && we_b) begin
            mem_b[adr_b[7:0]] <= dato_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem_s[i] <= pat(i);
        end else if (cyc_s && stb_s && we_s) begin
            mem_s[adr_s[7:0]] <= dato_s;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // R1: outputs quiet during reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!cyc_b && !stb_b, "R1 cyc/stb", {14'd0, cyc_b, stb_b}, 16'd0);
        chk(!oe_b && !oe_s, "R1 pad enable", {14'd0, oe_b, oe_s}, 16'd0);
        chk(ado_b == 16'd0, "R1 read data", ado_b, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Read access; stop_at > 0 raises chip-select after that edge (R8)
    task automatic t_read(input logic [15:0] a, input int stop_at);
        cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; ad_in = a;
        for (int k = 0; k <= 21; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 0) begin
                chk(oe_b == 1'b0, "R7 no drive with oe high", {15'd0, oe_b}, 16'd0);
                chk(cyc_b && adr_b == a, "R2 first address", adr_b, a);
                chk(cyc_s && adr_s == a, "R2 first address single", adr_s, a);
                chk(!stb_b || cyc_b, "R9 stb within cyc", {15'd0, cyc_b}, 16'd1);
                adv_n = 1'b1; oe_n = 1'b0; ad_in = '0;
            end
            if (k == 5) begin
                chk(ado_b == mem_b[a[7:0]], "R3 first word burst", ado_b, mem_b[a[7:0]]);
                chk(ado_s == mem_s[a[7:0]], "R3 first word single", ado_s, mem_s[a[7:0]]);
                chk(oe_b && oe_s, "R7 drive during read", {14'd0, oe_b, oe_s}, 16'd3);
            end else if (k > 5 && k <= 20) begin
                logic [7:0] idx;
                idx = a[7:0] + 8'(k - 5);
                chk(ado_b == mem_b[idx], "R4 burst word", ado_b, mem_b[idx]);
            end
            if (k == 12) begin
                chk(ado_s == mem_s[a[7:0]], "R5 single word held", ado_s, mem_s[a[7:0]]);
                chk(!cyc_s, "R5 single one transfer", {15'd0, cyc_s}, 16'd0);
            end
            if (stop_at > 0 && k == stop_at) break;
        end
        cs_n = 1'b1; oe_n = 1'b1; adv_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(!cyc_b, "R8 cycle dropped after cs high", {15'd0, cyc_b}, 16'd0);
        chk(!oe_b && !oe_s, "R7 released after cs high", {14'd0, oe_b, oe_s}, 16'd0);
    endtask

    // Write access of n beats; data value base + j
    task automatic t_write(input logic [15:0] a, input int n, input logic [15:0] base);
        int lim;
        lim = (n < 16) ? n : 16;
        cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; ad_in = a;
        @(posedge clk);
        @(negedge clk);
        adv_n = 1'b1;
        for (int j = 0; j < n; j++) begin
            ad_in = base + 16'(j);
            @(posedge clk);
            @(negedge clk);
            if (j == 0) begin
                chk(cyc_b && we_b && adr_b == a, "R6 write in next clock", adr_b, a);
                chk(cyc_s && we_s && adr_s == a, "R6 write in next clock single", adr_s, a);
                chk(stb_b && cyc_b, "R9 strobe with cycle", {14'd0, stb_b, cyc_b}, 16'd3);
            end
        end
        cs_n = 1'b1; we_n = 1'b1; ad_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int j = 0; j <= n; j++) begin
            logic [7:0]  idx;
            logic [15:0] exp;
            idx = a[7:0] + 8'(j);
            exp = (j < lim) ? base + 16'(j) : pat(int'(idx));
            if (j >= 16) chk(mem_b[idx] == exp, "R10 beat past limit", mem_b[idx], exp);
            else         chk(mem_b[idx] == exp, "R6 burst write data", mem_b[idx], exp);
        end
        chk(mem_s[a[7:0]] == base, "R6 single write data", mem_s[a[7:0]], base);
        chk(mem_s[a[7:0] + 8'd1] == pat(int'(a[7:0] + 8'd1)), "R5 later beat ignored",
            mem_s[a[7:0] + 8'd1], pat(int'(a[7:0] + 8'd1)));
    endtask

    initial begin
        t_reset();
        t_read(16'h0010, 0);          // R3 single-word timing in both builds
        t_read(16'h0040, 0);          // R4 full 16-word burst
        t_write(16'h0080, 3, 16'h7100);   // R6 short write
        t_write(16'h00A0, 18, 16'h5200);  // R10 over-long burst write
        t_read(16'h00A0, 0);          // R4 written data read back in order
        t_read(16'h0060, 8);          // R8 abort mid-burst
        t_read(16'h0030, 0);          // R8 next access returns its own data
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule